// File: doc/BRIEF.md
# Three-Wire Character Display Writer

This block lets a host write bytes to a character display that runs in 4-bit mode. The display sits behind an external serial-in, parallel-out register whose latch is held open. Only three wires leave the chip. The first is serial data. The second is a line that is both the shift clock and the register-select level. The third is the display enable strobe. Because the display's read/write pin is tied to write, the block never reads anything back.

The host presents a byte and a register-select flag, then pulses `start`. The block accepts the request only when it is idle, and it raises `busy` while the request runs. The byte goes out as two nibbles, high nibble first, each shifted most significant bit first. For each bit, the clock line goes low with the data bit applied and then goes high, so the external register shifts on that rising edge. After the fourth bit, the clock line is parked at the register-select level. A low park level causes no shift, because the register moves only on rising edges. After the park delay, enable is pulsed. After the second nibble, a fixed gap stands in for the display's execution time. When the gap ends, `busy` falls and `done` pulses for one cycle.

Top module: `lcd3w_writer`

## Requirements
- R1: While reset is asserted and right after it, `sclk_o` is 1, `sdata_o` is 0, `en_o` is 0, `busy` is 0 and `done` is 0.
- R2: A `start` sampled high while the block is idle captures `din` and `rs_in`, and `busy` is 1 from the next cycle on.
- R3: The bits go out high nibble first and most significant bit first, so byte bit 7-k is the k-th bit sent. Each bit holds `sclk_o` low for HALF_CYC cycles and then high for HALF_CYC cycles, with the bit on `sdata_o` through both halves.
- R4: After the fourth bit of a nibble, `sclk_o` takes the captured register-select value. It holds that value for HALF_CYC cycles before enable rises, through the enable pulse, and for HALF_CYC cycles after enable falls.
- R5: Each nibble gets exactly one enable pulse, and each pulse is EN_CYC cycles long. A byte therefore produces two pulses.
- R6: `sdata_o` never changes while `sclk_o` stays high. Exactly four rising edges of `sclk_o` occur between the end of one enable pulse and the end of the next.
- R7: `busy` stays high for exactly 2*(10*HALF_CYC+EN_CYC)+GAP_CYC cycles. On the cycle after the last busy cycle, `done` is 1 for exactly one cycle.
- R8: A `start` pulse while `busy` is 1 is ignored. No transfer of that byte ever reaches the display.
- R9: A `start` given during the cycle in which `done` is high is accepted, so requests can run back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request strobe, one cycle |
| din | input | 8 | Byte to write |
| rs_in | input | 1 | Register-select value for this byte |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse when a transfer ends |
| sdata_o | output | 1 | Serial data to the external register |
| sclk_o | output | 1 | Shift clock, parked at the register-select level |
| en_o | output | 1 | Display enable strobe |

## Verification
Every output is registered, so each effect of an accepted `start` appears in the first cycle after the sampling edge. From that point the reference model counts elapsed cycles t. It predicts `sclk_o`, `sdata_o`, `en_o` and `busy` at t from HALF_CYC, EN_CYC and GAP_CYC, and it predicts `done` at t equal to the full busy length. The bench samples all outputs on the falling clock edge, half a cycle after the registers update, and compares them with the model on every cycle. A behavioural model of the external register and the display rebuilds each byte and register-select flag from the enable falling edges. The bench checks the rebuilt bytes against the accepted requests in order.

// File: rtl/lcd3w_pkg.sv
package lcd3w_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_BIT_LO,
        PH_BIT_HI,
        PH_PARK,
        PH_ENA,
        PH_HOLD,
        PH_GAP
    } lcd3w_phase_e;

    typedef struct packed {
        lcd3w_phase_e ph;
        logic [7:0]   data;
        logic         rs;
        logic         nib;
        logic [1:0]   bidx;
        logic         sclk;
        logic         sdata;
        logic         en;
        logic         busy;
        logic         done;
    } lcd3w_state_t;

endpackage

// File: rtl/lcd3w_timer.sv
module lcd3w_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          zero
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero = (cnt_q == '0);

    // R7: the phase counter steps down by one per cycle when not reloaded
    assert_timer_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/lcd3w_bitsel.sv
module lcd3w_bitsel (
    input  logic [7:0] data,
    input  logic       nib,
    input  logic [1:0] bidx,
    output logic       bit_o
);
    logic [2:0] pos;

    // high nibble first, MSB first: k-th bit sent is data[7-k]
    assign pos   = 3'd7 - {nib, bidx};
    assign bit_o = data[pos];

endmodule

// File: rtl/lcd3w_writer.sv
module lcd3w_writer
    import lcd3w_pkg::*;
#(
    parameter int HALF_CYC = 4,
    parameter int EN_CYC   = 125,
    parameter int GAP_CYC  = 5000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [7:0] din,
    input  logic       rs_in,
    output logic       busy,
    output logic       done,
    output logic       sdata_o,
    output logic       sclk_o,
    output logic       en_o
);
    localparam int MAXC = (GAP_CYC > EN_CYC) ?
                          ((GAP_CYC > HALF_CYC) ? GAP_CYC : HALF_CYC) :
                          ((EN_CYC > HALF_CYC) ? EN_CYC : HALF_CYC);
    localparam int CW = $clog2(MAXC + 1);
    localparam logic [CW-1:0] LD_HALF = CW'(HALF_CYC - 1);
    localparam logic [CW-1:0] LD_EN   = CW'(EN_CYC - 1);
    localparam logic [CW-1:0] LD_GAP  = CW'(GAP_CYC - 1);

    lcd3w_state_t  st_d, st_q;
    logic          tmr_load;
    logic [CW-1:0] tmr_val;
    logic          tmr_zero;
    logic [1:0]    nxt_idx;
    logic          nxt_bit;

    lcd3w_timer #(.CW(CW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    assign nxt_idx = st_q.bidx + 2'd1;

    lcd3w_bitsel u_bitsel (
        .data  (st_q.data),
        .nib   (st_q.nib),
        .bidx  (nxt_idx),
        .bit_o (nxt_bit)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        tmr_load  = 1'b0;
        tmr_val   = LD_HALF;
        unique case (st_q.ph)
            PH_IDLE: begin
                if (start) begin
                    st_d.data  = din;
                    st_d.rs    = rs_in;
                    st_d.nib   = 1'b0;
                    st_d.bidx  = 2'd0;
                    st_d.sclk  = 1'b0;
                    st_d.sdata = din[7];
                    st_d.busy  = 1'b1;
                    st_d.ph    = PH_BIT_LO;
                    tmr_load   = 1'b1;
                end
            end
            PH_BIT_LO: begin
                if (tmr_zero) begin
                    st_d.sclk = 1'b1;
                    st_d.ph   = PH_BIT_HI;
                    tmr_load  = 1'b1;
                end
            end
            PH_BIT_HI: begin
                if (tmr_zero) begin
                    tmr_load = 1'b1;
                    if (st_q.bidx == 2'd3) begin
                        st_d.sclk = st_q.rs;
                        st_d.ph   = PH_PARK;
                    end else begin
                        st_d.bidx  = nxt_idx;
                        st_d.sclk  = 1'b0;
                        st_d.sdata = nxt_bit;
                        st_d.ph    = PH_BIT_LO;
                    end
                end
            end
            PH_PARK: begin
                if (tmr_zero) begin
                    st_d.en  = 1'b1;
                    st_d.ph  = PH_ENA;
                    tmr_load = 1'b1;
                    tmr_val  = LD_EN;
                end
            end
            PH_ENA: begin
                if (tmr_zero) begin
                    st_d.en  = 1'b0;
                    st_d.ph  = PH_HOLD;
                    tmr_load = 1'b1;
                end
            end
            PH_HOLD: begin
                if (tmr_zero) begin
                    tmr_load = 1'b1;
                    if (!st_q.nib) begin
                        st_d.nib   = 1'b1;
                        st_d.bidx  = 2'd0;
                        st_d.sclk  = 1'b0;
                        st_d.sdata = st_q.data[3];
                        st_d.ph    = PH_BIT_LO;
                    end else begin
                        st_d.ph = PH_GAP;
                        tmr_val = LD_GAP;
                    end
                end
            end
            PH_GAP: begin
                if (tmr_zero) begin
                    st_d.busy = 1'b0;
                    st_d.done = 1'b1;
                    st_d.ph   = PH_IDLE;
                end
            end
            default: st_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.ph    <= PH_IDLE;
            st_q.sclk  <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy    = st_q.busy;
    assign done    = st_q.done;
    assign sdata_o = st_q.sdata;
    assign sclk_o  = st_q.sclk;
    assign en_o    = st_q.en;

    // R4: clock line sits at the register-select level throughout enable
    assert_park_level_R4: assert property (@(posedge clk) disable iff (!rst_n)
        en_o |-> (sclk_o == st_q.rs));

    // R4: clock line does not move while enable stays high
    assert_sclk_steady_en_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (en_o && $past(en_o)) |-> $stable(sclk_o));

    // R6: serial data is frozen while the clock line stays high
    assert_data_steady_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_o && $past(sclk_o)) |-> $stable(sdata_o));

    // R5: enable only inside a transfer
    assert_en_in_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        en_o |-> busy);

    // R7: done is a single-cycle pulse marking the fall of busy
    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_done_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $fell(busy));

    // R8: start while busy leaves the captured byte untouched
    assert_ignore_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> $stable(st_q.data));

endmodule

// File: tb/tb_lcd3w_writer.sv
module tb_lcd3w_writer;
    localparam int H  = 4;
    localparam int E  = 125;
    localparam int G  = 5000;
    localparam int NL = 10 * H + E;
    localparam int T  = 2 * NL + G;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [7:0] din = 8'h00;
    logic       rs_in = 1'b0;
    logic       busy, done, sdata_o, sclk_o, en_o;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    lcd3w_writer #(.HALF_CYC(H), .EN_CYC(E), .GAP_CYC(G)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .din(din), .rs_in(rs_in),
        .busy(busy), .done(done), .sdata_o(sdata_o), .sclk_o(sclk_o), .en_o(en_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // ---------------- reference timeline model ----------------
    logic       m_active = 1'b0;
    logic       m_done = 1'b0;
    int         m_t = 0;
    logic [7:0] m_byte = 8'h00;
    logic       m_rs = 1'b0;
    logic       m_idle_sclk = 1'b1;
    logic [8:0] exp_q[$];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_active    <= 1'b0;
            m_done      <= 1'b0;
            m_idle_sclk <= 1'b1;
        end else if (m_active) begin
            if (m_t == T - 1) begin
                m_active    <= 1'b0;
                m_done      <= 1'b1;
                m_idle_sclk <= m_rs;
            end else begin
                m_t <= m_t + 1;
            end
        end else begin
            m_done <= 1'b0;
            if (start) begin
                m_active <= 1'b1;
                m_t      <= 0;
                m_byte   <= din;
                m_rs     <= rs_in;
                exp_q.push_back({rs_in, din});
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            logic esclk, een, esd;
            bit   chk_sd;
            esclk  = m_idle_sclk;
            een    = 1'b0;
            esd    = 1'b0;
            chk_sd = 0;
            if (m_active) begin
                int n, tp, b;
                n = m_t / NL;
                if (n >= 2) begin
                    esclk = m_rs;
                end else begin
                    tp = m_t - n * NL;
                    if (tp < 8 * H) begin
                        b      = tp / (2 * H);
                        esclk  = ((tp % (2 * H)) >= H);
                        esd    = m_byte[7 - (n * 4 + b)];
                        chk_sd = 1;
                    end else begin
                        esclk = m_rs;
                        een   = (tp >= 9 * H) && (tp < 9 * H + E);
                    end
                end
            end
            chk(busy === m_active, "R2/R7 busy", busy, m_active);
            chk(done === m_done, "R7 done", done, m_done);
            chk(sclk_o === esclk, "R3/R4 sclk", sclk_o, esclk);
            chk(en_o === een, "R5 enable", en_o, een);
            if (chk_sd) chk(sdata_o === esd, "R3 sdata", sdata_o, esd);
        end
    end

    // ---------------- external register + display model ----------------
    logic [3:0] ext_sr = 4'h0;
    int         edge_cnt = 0;
    logic       have_hi = 1'b0;
    logic [3:0] hi_nib = 4'h0;
    logic       hi_rs = 1'b0;
    logic [8:0] lcd_q[$];

    always @(posedge sclk_o) begin
        if (rst_n) begin
            ext_sr   <= {ext_sr[2:0], sdata_o};
            edge_cnt <= edge_cnt + 1;
        end
    end

    always @(negedge en_o) begin
        if (rst_n) begin
            chk(edge_cnt == 4, "R6 shift edges per nibble", edge_cnt, 4);
            edge_cnt <= 0;
            if (!have_hi) begin
                hi_nib  <= ext_sr;
                hi_rs   <= sclk_o;
                have_hi <= 1'b1;
            end else begin
                chk(sclk_o == hi_rs, "R4 rs same on both nibbles", sclk_o, hi_rs);
                lcd_q.push_back({sclk_o, hi_nib, ext_sr});
                have_hi <= 1'b0;
            end
        end
    end

    // ---------------- stimulus ----------------
    task automatic send(input logic [7:0] b, input logic r);
        @(negedge clk);
        while (busy) @(negedge clk);
        din   = b;
        rs_in = r;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset values
        chk(sclk_o === 1'b1, "R1 sclk", sclk_o, 1);
        chk(sdata_o === 1'b0, "R1 sdata", sdata_o, 0);
        chk(en_o === 1'b0, "R1 en", en_o, 0);
        chk(busy === 1'b0, "R1 busy", busy, 0);
        chk(done === 1'b0, "R1 done", done, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(sclk_o === 1'b1 && busy === 1'b0, "R1 after release", sclk_o, 1);

        send(8'hA5, 1'b0);
        send(8'h00, 1'b1);
        send(8'hFF, 1'b0);
        send(8'h3C, 1'b1);

        // R8: start while busy is ignored
        send(8'h5A, 1'b0);
        repeat (20) @(negedge clk);
        chk(busy === 1'b1, "R8 busy before stray start", busy, 1);
        din = 8'hC3; rs_in = 1'b1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;

        // R9: start in the done cycle is accepted
        while (!done) @(negedge clk);
        din = 8'h81; rs_in = 1'b1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy === 1'b1, "R9 back-to-back accepted", busy, 1);

        send(8'h96, 1'b0);
        @(negedge clk);
        while (busy) @(negedge clk);
        repeat (5) @(negedge clk);

        chk(exp_q.size() == 7, "R8 accepted request count", exp_q.size(), 7);
        chk(lcd_q.size() == exp_q.size(), "R5 bytes at display", lcd_q.size(), exp_q.size());
        for (int i = 0; i < exp_q.size() && i < lcd_q.size(); i++)
            chk(lcd_q[i] == exp_q[i], "R3/R4 rebuilt byte", lcd_q[i], exp_q[i]);
        for (int i = 0; i < lcd_q.size(); i++)
            chk(lcd_q[i][7:0] != 8'hC3, "R8 stray byte absent", lcd_q[i][7:0], 0);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule